// File: doc/BRIEF.md
# Two-Channel PWM Peripheral with Posted-Write Status

This block is a memory-mapped pulse-width modulator. Its register window has room for four channels; two are built. Each channel has four registers: control, prescaler, period and duty. Every write is posted into a shadow copy and raises a pending flag for that register. The flag drops by itself when the counter logic takes the value. Software polls a shared read-only status word and waits for the flag to clear before it writes that register again.

Each channel divides the clock by its prescaler setting to form a tick. It counts ticks from zero up to the period value and then wraps. Its output is active while the count is below the duty value. Control flags set the enable, the output polarity, whether new period and duty values wait for the wrap, whether a disable acts at once, and whether a prescaler or period write is forced in on the next clock. Writes use a single valid strobe with address and data. Reads are combinational from an address.

Top module: `pwmPeriph`

## Requirements
- R1: Channel c (0 or 1) has control at byte address c*0x10+0x0, prescaler at +0x4, period at +0x8 and duty at +0xC. A read returns the last value written, masked to 6, 10, 12 and 12 bits.
- R2: Slots 2 and 3 (0x20 to 0x3F) and every address from 0x44 up read zero, and writes there change nothing. The status word at 0x40 is read-only, and a write to it changes no register and no pending flag.
- R3: Status bit 8*c+k reads 1 from the clock edge that captures a write to register k of channel c, with k = 0 control, 1 prescaler, 2 period, 3 duty. A control write is taken on the following edge, which clears its flag.
- R4: Prescaler value p gives one tick every p+1 clocks. A prescaler write is taken on the next tick. With auto-load off, a period or duty write is taken on the next tick, so its flag clears within p+1 clocks.
- R5: With enable (control bit 0) set, the output period is (N+1)*(p+1) clocks for period value N, and the active time is D*(p+1) clocks for duty D <= N. D = 0 never goes active, and D = N leaves one inactive tick per period.
- R6: Control bit 1 complements the output at all times, so the inactive level while disabled is 1.
- R7: With control bit 2 (auto-load) set, period and duty writes are taken only at the wrap of the count. Their flags stay set until then. While the channel is stopped, every tick counts as a wrap.
- R8: Clearing enable with control bit 3 clear lets the current period run to its end. The output then holds the inactive level.
- R9: Clearing enable with control bit 3 set stops the count at once. The output is inactive within three clocks of the capturing edge.
- R10: Control bit 4 makes a prescaler write take effect on the next clock and restarts the tick divider. Control bit 5 does the same for period and duty writes and restarts the count at zero.
- R11: After reset, every register and status bit reads zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and counters |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 7 | Byte address of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 7 | Byte address of the read |
| rdData | output | 32 | Read data, combinational from rdAddr |
| pwmOut | output | 2 | One modulated output per channel |

## Verification
The hardest case to reach is a period and duty write that has been captured but is held back by auto-load. It has to sit pending while the old waveform is still playing. To get there, the stimulus picks a long period, waits for the output's rising edge, and writes the new values a few clocks into the period. At that moment the status flags and the unchanged output are both visible. The next full period is then measured to show that the new values started exactly at the wrap.

// File: rtl/pwmPkg.sv
`timescale 1ns/1ps
package pwmPkg;
  localparam int CTRL_W = 6;
  localparam int PRE_W  = 10;
  localparam int PER_W  = 12;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_INV  = 1;
  localparam int CB_AUTO = 2;
  localparam int CB_STOP = 3;
  localparam int CB_FPRE = 4;
  localparam int CB_FPER = 5;

  // pending-flag index inside one channel's status group
  localparam int PK_CTRL = 0;
  localparam int PK_PRE  = 1;
  localparam int PK_PER  = 2;
  localparam int PK_DUTY = 3;

  typedef struct packed {
    logic loadCtrl;
    logic loadPre;
    logic loadPer;
    logic loadDuty;
    logic restartPre;
    logic restartCnt;
  } chanStrobe_t;

  typedef struct packed {
    logic tick;
    logic boundary;
    logic autoLoad;
    logic forcePre;
    logic forcePer;
  } chanState_t;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [PRE_W-1:0]  pre;
    logic [PER_W-1:0]  per;
    logic [PER_W-1:0]  duty;
  } chanShadow_t;
endpackage

// File: rtl/pwmRegCtl.sv
`timescale 1ns/1ps
module pwmRegCtl import pwmPkg::*; #(
  parameter int NUM_CH  = 2,
  parameter int SLOT_CH = 4,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrValid,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [DATA_W-1:0]         rdData,
  input  chanState_t  [NUM_CH-1:0]  chState,
  output chanShadow_t [NUM_CH-1:0]  chShadow,
  output chanStrobe_t [NUM_CH-1:0]  chStrobe
);
  localparam int SLOT_W = (SLOT_CH > 1) ? $clog2(SLOT_CH) : 1;
  localparam int GRP_W  = 8;
  localparam int REG_N  = 4;

  logic [SLOT_W-1:0] wrSlot, rdSlot;
  logic [1:0]        wrReg, rdReg;
  logic              wrSpace;

  logic [NUM_CH-1:0][REG_N-1:0] wrHit, loadHit, pendQ;
  logic [NUM_CH-1:0]            perDue;
  chanShadow_t [NUM_CH-1:0]     shadowQ;

  assign wrSlot  = wrAddr[4 +: SLOT_W];
  assign wrReg   = wrAddr[3:2];
  assign rdSlot  = rdAddr[4 +: SLOT_W];
  assign rdReg   = rdAddr[3:2];
  assign wrSpace = wrValid && !wrAddr[ADDR_W-1];
  assign chShadow = shadowQ;

  // write decode: one hit per channel and register
  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int k = 0; k < REG_N; k++) begin
        wrHit[ch][k] = wrSpace && (wrSlot == SLOT_W'(ch)) && (wrReg == 2'(k));
      end
    end
  end

  // transfer strobes towards the datapath
  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      perDue[ch] = chState[ch].forcePer |
                   (chState[ch].autoLoad ? chState[ch].boundary : chState[ch].tick);
      chStrobe[ch].loadCtrl   = pendQ[ch][PK_CTRL];
      chStrobe[ch].loadPre    = pendQ[ch][PK_PRE] & (chState[ch].tick | chState[ch].forcePre);
      chStrobe[ch].restartPre = pendQ[ch][PK_PRE] & chState[ch].forcePre;
      chStrobe[ch].loadPer    = pendQ[ch][PK_PER] & perDue[ch];
      chStrobe[ch].loadDuty   = pendQ[ch][PK_DUTY] & perDue[ch];
      chStrobe[ch].restartCnt = chState[ch].forcePer &
                                (chStrobe[ch].loadPer | chStrobe[ch].loadDuty);
      loadHit[ch] = {chStrobe[ch].loadDuty, chStrobe[ch].loadPer,
                     chStrobe[ch].loadPre,  chStrobe[ch].loadCtrl};
    end
  end

  // shadow registers and pending flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
      pendQ   <= '0;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (wrHit[ch][PK_CTRL]) shadowQ[ch].ctrl <= wrData[CTRL_W-1:0];
        if (wrHit[ch][PK_PRE])  shadowQ[ch].pre  <= wrData[PRE_W-1:0];
        if (wrHit[ch][PK_PER])  shadowQ[ch].per  <= wrData[PER_W-1:0];
        if (wrHit[ch][PK_DUTY]) shadowQ[ch].duty <= wrData[PER_W-1:0];
        pendQ[ch] <= wrHit[ch] | (pendQ[ch] & ~loadHit[ch]);
      end
    end
  end

  // read mux: channel registers, status word, zero elsewhere
  always_comb begin
    rdData = '0;
    if (!rdAddr[ADDR_W-1]) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (rdSlot == SLOT_W'(ch)) begin
          case (rdReg)
            2'd0:    rdData = DATA_W'(shadowQ[ch].ctrl);
            2'd1:    rdData = DATA_W'(shadowQ[ch].pre);
            2'd2:    rdData = DATA_W'(shadowQ[ch].per);
            default: rdData = DATA_W'(shadowQ[ch].duty);
          endcase
        end
      end
    end else if (rdAddr[ADDR_W-2:0] == '0) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        rdData[GRP_W*ch +: REG_N] = pendQ[ch];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    for (genvar k = 0; k < REG_N; k++) begin : g_reg
      a_r3_pend_set: assert property (@(posedge clk) disable iff (!rstN)
        wrHit[ch][k] |=> pendQ[ch][k]);
    end
    a_r3_ctrl_clear: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[ch][PK_CTRL] && !wrHit[ch][PK_CTRL]) |=> !pendQ[ch][PK_CTRL]);
    a_r7_auto_hold: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[ch][PK_PER] && chState[ch].autoLoad && !chState[ch].forcePer &&
       !chState[ch].boundary) |=> pendQ[ch][PK_PER]);
    a_r10_force_pre: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[ch][PK_PRE] && chState[ch].forcePre && !wrHit[ch][PK_PRE])
      |=> !pendQ[ch][PK_PRE]);
  end
endmodule

// File: rtl/pwmChanDp.sv
`timescale 1ns/1ps
module pwmChanDp import pwmPkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  chanShadow_t shadow,
  input  chanStrobe_t strobe,
  output chanState_t  state,
  output logic        pwmOut
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [PRE_W-1:0]  preQ, preCnt;
  logic [PER_W-1:0]  perQ, dutyQ, cnt;
  logic              runQ, outQ;
  logic              tick, atEnd, en, stopNow;

  assign en      = ctrlQ[CB_EN];
  assign stopNow = !ctrlQ[CB_EN] && ctrlQ[CB_STOP];
  assign tick    = (preCnt >= preQ);
  assign atEnd   = (cnt >= perQ);

  assign state.tick     = tick;
  assign state.boundary = tick && (!runQ || atEnd);
  assign state.autoLoad = ctrlQ[CB_AUTO];
  assign state.forcePre = ctrlQ[CB_FPRE];
  assign state.forcePer = ctrlQ[CB_FPER];
  assign pwmOut         = outQ;

  // active copies of the configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      preQ  <= '0;
      perQ  <= '0;
      dutyQ <= '0;
    end else begin
      if (strobe.loadCtrl) ctrlQ <= shadow.ctrl;
      if (strobe.loadPre)  preQ  <= shadow.pre;
      if (strobe.loadPer)  perQ  <= shadow.per;
      if (strobe.loadDuty) dutyQ <= shadow.duty;
    end
  end

  // tick divider
  always_ff @(posedge clk) begin
    if (!rstN)                        preCnt <= '0;
    else if (strobe.restartPre || tick) preCnt <= '0;
    else                              preCnt <= preCnt + 1'b1;
  end

  // period counter and run state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
      cnt  <= '0;
    end else if (stopNow) begin
      runQ <= 1'b0;
      cnt  <= '0;
    end else if (strobe.restartCnt) begin
      cnt <= '0;
    end else if (tick) begin
      if (runQ) begin
        if (atEnd) begin
          cnt <= '0;
          if (!en) runQ <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (en) begin
        runQ <= 1'b1;
        cnt  <= '0;
      end
    end
  end

  // registered compare and polarity
  always_ff @(posedge clk) begin
    if (!rstN) outQ <= 1'b0;
    else       outQ <= (runQ && (cnt < dutyQ)) ^ ctrlQ[CB_INV];
  end

  a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preQ);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> (cnt == '0));
  a_r9_stop_now: assert property (@(posedge clk) disable iff (!rstN)
    stopNow |=> !runQ);
  a_r5_duty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dutyQ == '0) |=> (outQ == $past(ctrlQ[CB_INV])));
endmodule

// File: rtl/pwmPeriph.sv
`timescale 1ns/1ps
module pwmPeriph import pwmPkg::*; #(
  parameter int NUM_CH  = 2,
  parameter int SLOT_CH = 4,
  parameter int ADDR_W  = $clog2(SLOT_CH*16) + 1,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanState_t  [NUM_CH-1:0] chState;
  chanShadow_t [NUM_CH-1:0] chShadow;
  chanStrobe_t [NUM_CH-1:0] chStrobe;

  pwmRegCtl #(
    .NUM_CH(NUM_CH), .SLOT_CH(SLOT_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .chState(chState), .chShadow(chShadow), .chStrobe(chStrobe)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pwmChanDp u_dp (
      .clk(clk), .rstN(rstN),
      .shadow(chShadow[ch]), .strobe(chStrobe[ch]),
      .state(chState[ch]), .pwmOut(pwmOut[ch])
    );
  end
endmodule

// File: tb/pwmPeriph_bench.sv
`timescale 1ns/1ps
module pwmPeriph_bench;
  localparam int LIMIT = 20000;
  localparam int NV = 6;
  // pre, per, duty, invert
  localparam int VEC [NV][4] = '{
    '{0, 9, 3, 0}, '{2, 7, 5, 0}, '{4, 3, 3, 0},
    '{1, 15, 1, 1}, '{9, 4, 2, 0}, '{3, 5, 5, 1}};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [6:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [1:0]  pwmOut;
  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pwmPeriph u_pwmPeriph (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = 7'(addr); wrData = data;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic regRead(input int addr, output logic [31:0] data);
    rdAddr = 7'(addr);
    #1;
    data = rdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle(input int ch);
    logic [31:0] st;
    int guard = 0;
    regRead(32'h40, st);
    while (((st >> (8*ch)) & 32'hF) != 0 && guard < 3000) begin
      @(negedge clk); guard++; regRead(32'h40, st);
    end
    if (guard >= 3000) check("R3", "pending flags never cleared", 1, 0);
  endtask

  task automatic setup(input int ch, input int pre, input int per, input int duty, input int ctrl);
    regWrite(ch*16 + 0, 32'h8);
    regWrite(ch*16 + 4, 32'(pre));
    regWrite(ch*16 + 8, 32'(per));
    regWrite(ch*16 + 12, 32'(duty));
    waitIdle(ch);
    regWrite(ch*16 + 0, 32'(ctrl));
    waitIdle(ch);
  endtask

  task automatic waitActive(input int ch, input logic lvl);
    int guard = 0;
    while (pwmOut[ch] == lvl && guard < LIMIT) begin @(negedge clk); guard++; end
    while (pwmOut[ch] != lvl && guard < LIMIT) begin @(negedge clk); guard++; end
  endtask

  task automatic measure(input int ch, input logic lvl, output int act, output int tot);
    int guard = 0;
    logic prev, cur;
    waitActive(ch, lvl);
    act = 1; tot = 1; prev = lvl;
    while (guard < LIMIT) begin
      @(negedge clk); guard++;
      cur = pwmOut[ch];
      if (cur == lvl && prev != lvl) break;
      tot++;
      if (cur == lvl) act++;
      prev = cur;
    end
    if (guard >= LIMIT) tot = -1;
  endtask

  task automatic countHigh(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); if (pwmOut[ch]) hi++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int act, tot, hi, bad, cyc;

    waitCycles(5);
    // R11: reset state
    bad = 0;
    for (int a = 0; a <= 32'h44; a += 4) begin
      regRead(a, v);
      if (v != 0) bad++;
    end
    check("R11", "nonzero registers in reset", bad, 0);
    check("R11", "outputs in reset", pwmOut, 0);
    rstN = 1'b1;
    waitCycles(2);
    check("R11", "outputs after reset", pwmOut, 0);

    // R5/R6/R4: vector table walk
    for (int i = 0; i < NV; i++) begin
      setup(0, VEC[i][0], VEC[i][1], VEC[i][2], 1 | (VEC[i][3] << 1));
      measure(0, VEC[i][3] == 0, act, tot);
      measure(0, VEC[i][3] == 0, act, tot);
      check("R5", $sformatf("period vec%0d", i), tot, (VEC[i][1] + 1) * (VEC[i][0] + 1));
      check(VEC[i][3] != 0 ? "R6" : "R5", $sformatf("active time vec%0d", i),
            act, VEC[i][2] * (VEC[i][0] + 1));
    end

    // R3: control flag lasts one cycle
    setup(0, 0, 9, 3, 1);
    regWrite(0, 32'h1);
    regRead(32'h40, v);
    check("R3", "control pending after write", v[0], 1);
    waitCycles(1);
    regRead(32'h40, v);
    check("R3", "control pending next cycle", v[0], 0);

    // R4: period flag with prescaler 9 clears within 10 clocks
    setup(0, 9, 4, 2, 1);
    regWrite(8, 32'd4);
    cyc = 0;
    regRead(32'h40, v);
    while (v[2] && cyc < 50) begin @(negedge clk); cyc++; regRead(32'h40, v); end
    check("R4", "period flag cleared in window", (cyc >= 1 && cyc <= 10), 1);

    // channel 1 waveform and status position
    setup(1, 1, 4, 2, 1);
    measure(1, 1'b1, act, tot);
    measure(1, 1'b1, act, tot);
    check("R5", "ch1 period", tot, 10);
    check("R5", "ch1 active time", act, 4);
    regWrite(32'h18, 32'd4);
    regRead(32'h40, v);
    check("R3", "ch1 period flag at bit 10", {v[10], v[3:0]}, 5'b10000);
    waitIdle(1);

    // R5: duty zero stays inactive
    setup(0, 0, 9, 0, 1);
    countHigh(0, 40, hi);
    check("R5", "duty zero active cycles", hi, 0);
    // R6: inactive level while disabled with invert
    regWrite(0, 32'hA);
    waitCycles(4);
    check("R6", "inverted idle level", pwmOut[0], 1);

    // R7: auto-load holds the new values until the wrap
    setup(0, 0, 63, 40, 5);
    waitActive(0, 1'b1);
    regWrite(8, 32'd31);
    regWrite(12, 32'd8);
    waitCycles(3);
    regRead(32'h40, v);
    check("R7", "flags held mid-period", v[3:2], 2'b11);
    check("R7", "old duty still active", pwmOut[0], 1);
    measure(0, 1'b1, act, tot);
    check("R7", "new period after wrap", tot, 32);
    check("R7", "new active time after wrap", act, 8);
    regRead(32'h40, v);
    check("R7", "flags clear after wrap", v[3:0], 0);

    // R8: graceful disable finishes the period
    setup(0, 0, 63, 40, 1);
    waitActive(0, 1'b1);
    hi = 1;
    wrValid = 1'b1; wrAddr = 7'h00; wrData = 32'h0;
    @(negedge clk);
    wrValid = 1'b0;
    bad = 0;
    while (pwmOut[0] && bad < 200) begin hi++; bad++; @(negedge clk); end
    check("R8", "final period active time", hi, 40);
    countHigh(0, 130, hi);
    check("R8", "inactive after final period", hi, 0);

    // R9: immediate stop
    setup(0, 0, 63, 40, 1);
    waitActive(0, 1'b1);
    regWrite(0, 32'h8);
    waitCycles(3);
    check("R9", "output dropped", pwmOut[0], 0);
    countHigh(0, 130, hi);
    check("R9", "stays inactive", hi, 0);

    // R10: forced prescaler and period loads
    setup(0, 9, 4, 2, 32'h11);
    regWrite(4, 32'd3);
    regRead(32'h40, v);
    check("R10", "forced prescaler flag set", v[1], 1);
    waitCycles(1);
    regRead(32'h40, v);
    check("R10", "forced prescaler flag cleared", v[1], 0);
    measure(0, 1'b1, act, tot);
    measure(0, 1'b1, act, tot);
    check("R10", "period after forced prescaler", tot, 20);
    setup(0, 9, 4, 2, 32'h21);
    regWrite(8, 32'd7);
    waitCycles(1);
    regRead(32'h40, v);
    check("R10", "forced period flag cleared", v[2], 0);
    measure(0, 1'b1, act, tot);
    measure(0, 1'b1, act, tot);
    check("R10", "period after forced load", tot, 80);

    // R2: unimplemented slots and read-only status
    waitIdle(0);
    regWrite(32'h20, 32'h55);
    regWrite(32'h34, 32'h77);
    regWrite(32'h40, 32'hFFFFFFFF);
    regRead(32'h20, v);
    check("R2", "slot 2 reads zero", v, 0);
    regRead(32'h34, v);
    check("R2", "slot 3 reads zero", v, 0);
    regRead(32'h40, v);
    check("R2", "status unchanged by write", v, 0);
    regRead(32'h44, v);
    check("R2", "above status reads zero", v, 0);
    regRead(8, v);
    check("R2", "ch0 period untouched", v, 7);

    // R1: readback masking on channel 1
    regWrite(32'h14, 32'hFFFFFFFF);
    regWrite(32'h18, 32'hFFFFFFFF);
    regWrite(32'h1C, 32'h00000ABC);
    regWrite(32'h10, 32'hFFFFFFC9);
    regRead(32'h14, v);
    check("R1", "ch1 prescaler mask", v, 32'h3FF);
    regRead(32'h18, v);
    check("R1", "ch1 period mask", v, 32'hFFF);
    regRead(32'h1C, v);
    check("R1", "ch1 duty", v, 32'hABC);
    regRead(32'h10, v);
    check("R1", "ch1 control mask", v, 32'h09);
    regRead(32'h0C, v);
    check("R1", "ch0 duty", v, 2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule